// File: doc/BRIEF.md
# Tri-Colour LED Step Sequencer

This block walks a tri-colour LED through all seven colour combinations and an all-dark state, one step per slow tick. The slow tick comes from the fast system clock. A power-of-two or general prescaler first produces a clock-enable pulse. Three cascaded square-wave divide stages then run on that enable. The default values (prescale 8, then stages of 500, 250 and 50) turn a 50 MHz clock into a 1 Hz wave.

The LED lines behave as open-drain pins. A colour element is lit by driving its line low. It is dark when its driver is switched off (high impedance), and it is never driven high. Each pin is therefore brought out as a drive-enable bit together with an output value that is always low. The final slow wave is also brought out, so that the divider timing can be observed.

All registers run on the one input clock. The slow domain is the set of cycles in which the prescaler enable is high. Every count value is a parameter, so simulation can use small values.

Top module: `led_sequencer`

## Requirements
- R1: The prescaler produces one enable pulse every PRESCALE input clocks. After reset is released, the first pulse falls in the PRESCALE-th clock. All divide stages and the colour counter change state only in enable cycles.
- R2: Stage 0 counts every enable pulse. Each later stage counts once per rising edge of the previous stage's wave, and that edge is detected one enable pulse after it occurs. The colour counter therefore first steps at enable pulse DIV_A*DIV_B*DIV_C+3 and then every DIV_A*DIV_B*DIV_C pulses.
- R3: Each stage wave with divide value N is high for ceil(N/2) and low for floor(N/2) of its input events, so an odd N gives a high phase one event longer than the low phase. `sec_wave` is the wave of the last stage.
- R4: The 3-bit colour count increases by exactly one on each step and wraps from 7 to 0. It changes at no other time.
- R5: Bit 0 of the count enables the red driver, bit 1 the green driver and bit 2 the blue driver (`led_drive_en[0]`, `[1]` and `[2]` respectively). A count of 0 leaves all three drivers off.
- R6: `led_out` is 0 in every cycle. A lit element is always pulled low, and an element that is off is released, never driven high.
- R7: A synchronous reset clears the prescaler, every stage counter and the colour count. In the cycle after a reset edge, all drivers are off and `sec_wave` is high. The sequence then restarts from the same timing as after power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| led_drive_en | output | 3 | Driver enable per element (0 red, 1 green, 2 blue); 1 pulls the line low |
| led_out | output | 3 | Value placed on each line when its driver is on; always 0 |
| sec_wave | output | 1 | Square wave from the last divide stage |

## Verification
Every result is due a fixed number of clocks after reset is released. An enable pulse falls on clock PRESCALE*j. The stage waves and the colour count change on the clock edge of the enable pulse in which their counters step, and the bench samples them on the falling edge that follows. From the clock count since reset, the bench computes how many enable pulses have passed, how many counts the last stage has made and how many colour steps have occurred. These follow the offsets given in R2. The bench then compares all outputs on every cycle, both before and after a reset applied mid-run.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;
   localparam int RED_BIT   = 0;
   localparam int GREEN_BIT = 1;
   localparam int BLUE_BIT  = 2;
   localparam int COLOUR_W  = 3;

   typedef logic [COLOUR_W-1:0] colour_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/led_prescaler.sv
module led_prescaler #(
   parameter int unsigned PRESCALE = 8
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int unsigned PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;

   logic [PW-1:0] pcnt;

   if (PRESCALE < 2) begin : g_bad_prescale
      $error("led_prescaler: PRESCALE must be at least 2");
   end

   if (led_seq_pkg::is_pow2(PRESCALE)) begin : g_pow2
      // natural wrap of a power-of-two counter
      always_ff @(posedge clk) begin
         if (rst) pcnt <= '0;
         else     pcnt <= pcnt + 1'b1;
      end
      assign tick = &pcnt;
   end else begin : g_general
      always_ff @(posedge clk) begin
         if (rst)                           pcnt <= '0;
         else if (pcnt == PW'(PRESCALE - 1)) pcnt <= '0;
         else                               pcnt <= pcnt + 1'b1;
      end
      assign tick = (pcnt == PW'(PRESCALE - 1));
   end
endmodule

// File: rtl/sq_div_stage.sv
module sq_div_stage #(
   parameter int unsigned DIV   = 500,
   parameter int unsigned CNT_W = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic adv,
   output logic wave,
   output logic rise
);
   localparam int unsigned HIGH_LEN = (DIV + 1) / 2;

   logic [CNT_W-1:0] cnt;
   logic             wave_prev;

   if (DIV < 2) begin : g_bad_div
      $error("sq_div_stage: DIV must be at least 2");
   end
   if (DIV >= (64'd1 << CNT_W)) begin : g_bad_width
      $error("sq_div_stage: DIV does not fit in CNT_W bits");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (tick && adv) begin
         if (cnt == CNT_W'(DIV - 1)) cnt <= '0;
         else                        cnt <= cnt + 1'b1;
      end
   end

   assign wave = (cnt < CNT_W'(HIGH_LEN));

   // edge detector sampled in the slow domain; reset high so no false edge
   always_ff @(posedge clk) begin
      if (rst)       wave_prev <= 1'b1;
      else if (tick) wave_prev <= wave;
   end

   assign rise = wave & ~wave_prev;
endmodule

// File: rtl/colour_step.sv
module colour_step
   import led_seq_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    tick,
   input  logic    step,
   output colour_t colour
);
   always_ff @(posedge clk) begin
      if (rst)               colour <= '0;
      else if (tick && step) colour <= colour + 1'b1;
   end
endmodule

// File: rtl/led_sequencer.sv
module led_sequencer
   import led_seq_pkg::*;
#(
   parameter int unsigned PRESCALE = 8,
   parameter int unsigned DIV_A    = 500,
   parameter int unsigned DIV_B    = 250,
   parameter int unsigned DIV_C    = 50,
   parameter int unsigned CNT_W    = 16
) (
   input  logic       clk,
   input  logic       rst,
   output logic [2:0] led_drive_en,
   output logic [2:0] led_out,
   output logic       sec_wave
);
   localparam int NUM_STAGES = 3;
   localparam int unsigned STAGE_DIV [NUM_STAGES] = '{DIV_A, DIV_B, DIV_C};

   logic                  pre_tick;
   logic [NUM_STAGES-1:0] st_wave;
   logic [NUM_STAGES:0]   st_adv;
   colour_t               colour;

   led_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk  (clk),
      .rst  (rst),
      .tick (pre_tick)
   );

   assign st_adv[0] = 1'b1;

   for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_stage
      sq_div_stage #(.DIV(STAGE_DIV[gi]), .CNT_W(CNT_W)) u_div (
         .clk  (clk),
         .rst  (rst),
         .tick (pre_tick),
         .adv  (st_adv[gi]),
         .wave (st_wave[gi]),
         .rise (st_adv[gi+1])
      );
   end

   colour_step u_col (
      .clk    (clk),
      .rst    (rst),
      .tick   (pre_tick),
      .step   (st_adv[NUM_STAGES]),
      .colour (colour)
   );

   assign led_drive_en[0] = colour[RED_BIT];
   assign led_drive_en[1] = colour[GREEN_BIT];
   assign led_drive_en[2] = colour[BLUE_BIT];
   assign led_out         = '0;
   assign sec_wave        = st_wave[NUM_STAGES-1];
endmodule

// File: rtl/led_seq_chk.sv
module led_seq_chk #(
   parameter int unsigned DIV_A = 500,
   parameter int unsigned DIV_B = 250,
   parameter int unsigned DIV_C = 50
) (
   input logic       clk,
   input logic       rst,
   input logic       pre_tick,
   input logic [2:0] led_drive_en,
   input logic       sec_wave
);
   localparam int unsigned EV_PER_C = DIV_A * DIV_B;
   localparam int unsigned HI_TICKS = ((DIV_C + 1) / 2) * EV_PER_C;
   localparam int unsigned LO_TICKS = (DIV_C / 2) * EV_PER_C;
   localparam int unsigned STEP_GAP = DIV_A * DIV_B * DIV_C;

   logic [2:0]  prev_en;
   logic        chg, seen_chg;
   logic [31:0] gap_cnt, hi_cnt, lo_cnt;
   logic        wave_q, seen_rise, seen_fall;

   assign chg = (led_drive_en != prev_en);

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_en   <= '0;
         seen_chg  <= 1'b0;
         gap_cnt   <= '0;
         hi_cnt    <= '0;
         lo_cnt    <= '0;
         wave_q    <= 1'b1;
         seen_rise <= 1'b0;
         seen_fall <= 1'b0;
      end else begin
         prev_en <= led_drive_en;
         if (chg) begin
            seen_chg <= 1'b1;
            gap_cnt  <= '0;
         end else if (pre_tick) begin
            gap_cnt <= gap_cnt + 1;
         end
         wave_q <= sec_wave;
         if (sec_wave && !wave_q) seen_rise <= 1'b1;
         if (!sec_wave && wave_q) seen_fall <= 1'b1;
         hi_cnt <= sec_wave ? hi_cnt + {31'd0, pre_tick} : '0;
         lo_cnt <= sec_wave ? '0 : lo_cnt + {31'd0, pre_tick};
      end
   end

   // R4: colour count steps by exactly one, wrapping 7 to 0
   assert_step_by_one_R4: assert property (@(posedge clk) disable iff (rst)
      chg |-> (led_drive_en == 3'(prev_en + 3'd1)));

   // R2: spacing between colour steps equals the product of the stage divides
   assert_step_period_R2: assert property (@(posedge clk) disable iff (rst)
      (chg && seen_chg) |-> (gap_cnt == 32'(STEP_GAP)));

   // R3: high phase of the last stage wave
   assert_high_phase_R3: assert property (@(posedge clk) disable iff (rst)
      (!sec_wave && wave_q && seen_rise) |-> (hi_cnt == 32'(HI_TICKS)));

   // R3: low phase of the last stage wave
   assert_low_phase_R3: assert property (@(posedge clk) disable iff (rst)
      (sec_wave && !wave_q && seen_fall) |-> (lo_cnt == 32'(LO_TICKS)));

   // R7: reset darkens every element and parks the wave high
   assert_reset_state_R7: assert property (@(posedge clk)
      rst |=> (led_drive_en == 3'b000 && sec_wave));
endmodule

bind led_sequencer led_seq_chk #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .pre_tick     (pre_tick),
   .led_drive_en (led_drive_en),
   .sec_wave     (sec_wave)
);

// File: tb/tb_led_sequencer.sv
module tb_led_sequencer;
   localparam int PRE = 4;
   localparam int DA  = 3;
   localparam int DB  = 2;
   localparam int DC  = 5;
   localparam int PRD = DA * DB * DC;
   localparam int C_START = DA * DB + 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] led_drive_en;
   logic [2:0] led_out;
   logic       sec_wave;
   int         cyc;
   int         n_checks = 0;
   int         n_errors = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   led_sequencer #(.PRESCALE(PRE), .DIV_A(DA), .DIV_B(DB), .DIV_C(DC)) dut (
      .clk          (clk),
      .rst          (rst),
      .led_drive_en (led_drive_en),
      .led_out      (led_out),
      .sec_wave     (sec_wave)
   );

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   function automatic int exp_colour(input int n);
      int t = n / PRE;
      if (t < PRD + 3) return 0;
      return ((t - PRD - 3) / PRD + 1) % 8;
   endfunction

   function automatic int exp_wave(input int n);
      int t = n / PRE;
      int c = (t >= C_START) ? (t - C_START) / (DA * DB) + 1 : 0;
      return ((c % DC) < (DC + 1) / 2) ? 1 : 0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic sweep(input int ncyc);
      for (int i = 0; i < ncyc; i++) begin
         int ec, ew;
         @(negedge clk);
         ec = exp_colour(cyc);
         ew = exp_wave(cyc);
         // R1 R2 R4: colour count timing from prescale and stage cascade
         check(int'(led_drive_en) == ec, "R1 R2 R4 colour count", int'(led_drive_en), ec);
         // R5: element mapping (red bit 0, green bit 1, blue bit 2)
         check(led_drive_en[0] == ec[0] && led_drive_en[1] == ec[1] && led_drive_en[2] == ec[2],
               "R5 element map", int'(led_drive_en), ec);
         // R6: never driven high
         check(led_out == 3'b000, "R6 line level", int'(led_out), 0);
         // R3: last stage square wave
         check(int'(sec_wave) == ew, "R3 slow wave", int'(sec_wave), ew);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R7: state during reset
      check(led_drive_en == 3'b000 && sec_wave, "R7 reset state", int'(led_drive_en), 0);
      rst = 1'b0;
      sweep(2500);
      // mid-run reset while colours are lit
      rst = 1'b1;
      @(negedge clk);
      check(led_drive_en == 3'b000, "R7 drivers off in reset", int'(led_drive_en), 0);
      check(sec_wave == 1'b1, "R7 wave high in reset", int'(sec_wave), 1);
      @(negedge clk);
      rst = 1'b0;
      sweep(1500);
      done = 1'b1;
   end

   initial begin
      for (int w = 0; w < 200000; w++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      end
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule